// File: doc/BRIEF.md
# Interrupt Redirection Dispatch Engine

This block collects interrupt requests from a set of numbered request lines, keeps a pending bit for every pin, and turns each pending, unmasked pin into one delivery message for a local interrupt controller. A per-pin 64-bit redirection word sets how each pin is treated: its vector, delivery kind, destination, polarity, whether it is masked, and whether it is edge- or level-sensitive. Messages leave through a registered valid/ready port, one per handshake.

Edge pins are consumed when their message is issued. A request that arrives while the pin is masked is thrown away, so it cannot come back later as a stuck request. Level pins stay pending for as long as their line is held high. Issuing a level pin sets a remote-in-service flag, and that flag blocks any further message until an end-of-interrupt broadcast with the same vector clears it. Each request strobe, each end-of-interrupt that re-arms a waiting pin, and each external re-service pulse starts a service pass. The pass keeps issuing messages, lowest pin first, until no eligible pin is left.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every redirection word reads as masked, all pending and remote-in-service bits are 0, and `msg_valid` is low.
- R2: The message fields are taken from the pin's word as follows: vector from bits 7:0, delivery kind from 10:8, destination mode from bit 11, polarity from bit 13, trigger from bit 15 (0 edge, 1 level), mask from bit 16, and destination from 63:56.
- R3: A rising request on an unmasked edge pin produces exactly one message. The pin's pending bit is 0 once that message has been issued.
- R4: A request on a masked edge pin is dropped. Its pending bit stays 0, and no message follows even after the pin is later unmasked and a re-service pulse is given.
- R5: Asserting a level pin sets its pending bit and issues one message, which sets the pin's remote-in-service bit. Further passes do not deliver that pin again while the bit stays set. Deasserting the line clears the pending bit.
- R6: An end-of-interrupt carrying vector V clears the remote-in-service bit of every pin whose bit is set and whose vector equals V, and leaves the bit alone when the vector differs. If the cleared pin is still pending and unmasked, it is delivered again.
- R7: Request line 0 acts on pin 2, every other line below the pin count acts on the pin with the same number, and lines at or above the pin count change nothing.
- R8: When several pins are eligible at once, they are issued in ascending pin order.
- R9: While `msg_valid` is high and `msg_ready` is low, every message output holds its value. Each accepted handshake carries exactly one message.
- R10: A pin whose delivery kind is 7 (external-controller fetch) issues its message with the vector field set to 0.
- R11: A pending level pin that becomes unmasked through a word rewrite is delivered only after the next `resvc` pulse.
- R12: An edge request that arrives in the same cycle as the issue of an earlier request on the same pin is kept, and the pin produces a second message.
- R13: Writing a word leaves the pin's remote-in-service bit unchanged, whatever value bit 14 of the written data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 1 | Request event strobe |
| req_line | input | LINE_W | Request line number |
| req_lvl | input | 1 | New line level (1 raise, 0 lower) |
| eoi_stb | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vec | input | 8 | Vector carried by the end-of-interrupt |
| resvc | input | 1 | One-cycle pulse that starts a service pass |
| cfg_we | input | 1 | Redirection word write enable |
| cfg_idx | input | IDX_W | Pin whose word is written |
| cfg_data | input | 64 | Redirection word data |
| msg_valid | output | 1 | Message is valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_pin | output | IDX_W | Pin that produced the message |
| msg_dest | output | 8 | Destination |
| msg_dmode | output | 1 | Destination mode |
| msg_dlv | output | 3 | Delivery kind |
| msg_vec | output | 8 | Vector (0 for kind 7) |
| msg_pol | output | 1 | Polarity |
| msg_trig | output | 1 | Trigger mode |
| pend_o | output | NUM_PINS | Pending bit of each pin |
| rirr_o | output | NUM_PINS | Remote-in-service bit of each pin |

## Verification
Two functions can act on the same pin bit in one clock edge: the issue of an edge pin clears its pending bit, and a new request for that pin sets it. The bench raises this case by strobing the same edge line in two consecutive cycles with the consumer ready, so that the second strobe lands on the edge where the first request is issued. The scoreboard then expects two identical messages for that pin and a cleared pending bit after both. The same scoreboard also follows an end-of-interrupt that re-arms a level pin which is still held high, and checks that exactly one further message results.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;
  localparam logic [2:0] DLV_EXT_FETCH = 3'd7;

  // Only the fields the engine acts on are kept per pin.
  typedef struct packed {
    logic [7:0] dest;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
    logic       pol;
    logic       trig;
    logic       mask;
  } rte_t;

  typedef struct packed {
    logic [7:0] dest;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
    logic       pol;
    logic       trig;
  } msg_t;

  localparam rte_t RTE_RESET = '{dest: 8'h0, dmode: 1'b0, dlv: 3'h0, vec: 8'h0,
                                 pol: 1'b0, trig: 1'b0, mask: 1'b1};

  function automatic rte_t rte_decode(input logic [63:0] w);
    rte_t e;
    e.dest  = w[DEST_LSB +: 8];
    e.dmode = w[DMODE_BIT];
    e.dlv   = w[DLV_LSB +: 3];
    e.vec   = w[VEC_LSB +: 8];
    e.pol   = w[POL_BIT];
    e.trig  = w[TRIG_BIT];
    e.mask  = w[MASK_BIT];
    return e;
  endfunction

  function automatic msg_t rte_to_msg(input rte_t e);
    msg_t m;
    m.dest  = e.dest;
    m.dmode = e.dmode;
    m.dlv   = e.dlv;
    m.vec   = (e.dlv == DLV_EXT_FETCH) ? 8'h00 : e.vec;
    m.pol   = e.pol;
    m.trig  = e.trig;
    return m;
  endfunction

endpackage

// File: rtl/redir_table.sv
module redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [63:0]      wdata,
  output rte_t             ent [NUM_PINS]
);

  // Decode on write; the remote flag bit of wdata has no storage here.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= RTE_RESET;
      else if (we && idx == IDX_W'(i))
        ent[i] <= rte_decode(wdata);
    end
  end

endmodule

// File: rtl/pend_tracker.sv
module pend_tracker #(
  parameter int NUM_PINS = 24,
  parameter int LINE_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_stb,
  input  logic [LINE_W-1:0]   req_line,
  input  logic                req_lvl,
  input  logic                eoi_stb,
  input  logic [7:0]          eoi_vec,
  input  logic                resvc,
  input  logic [NUM_PINS-1:0] mask_v,
  input  logic [NUM_PINS-1:0] trig_v,
  input  logic [7:0]          vec_a [NUM_PINS],
  input  logic [NUM_PINS-1:0] take,
  output logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] rirr,
  output logic [NUM_PINS-1:0] cand
);

  function automatic logic [LINE_W-1:0] remap_line(input logic [LINE_W-1:0] l);
    return (l == '0) ? LINE_W'(2) : l;
  endfunction

  logic [LINE_W-1:0]   line_m;
  logic                line_ok;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] eoi_hit;
  logic                armed;
  logic                wake;

  assign line_m  = remap_line(req_line);
  assign line_ok = int'(line_m) < NUM_PINS;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign hit[i]     = req_stb && line_ok && (line_m == LINE_W'(i));
    assign eoi_hit[i] = eoi_stb && rirr[i] && (vec_a[i] == eoi_vec);
    assign cand[i]    = armed && pend[i] && !mask_v[i] && (!trig_v[i] || !rirr[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        rirr[i] <= 1'b0;
      end else begin
        if (trig_v[i]) begin
          if (hit[i]) pend[i] <= req_lvl;
        end else begin
          if (hit[i] && req_lvl && !mask_v[i]) pend[i] <= 1'b1;
          else if (take[i] || (armed && mask_v[i])) pend[i] <= 1'b0;
        end
        if (take[i] && trig_v[i]) rirr[i] <= 1'b1;
        else if (eoi_hit[i])      rirr[i] <= 1'b0;
      end
    end
  end

  assign wake = (req_stb && line_ok) || resvc || |(eoi_hit & pend & ~mask_v);

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= wake || (armed && |cand);
  end

endmodule

// File: rtl/pick_lowest.sv
module pick_lowest #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  assign grant = cand & (~cand + N'(1));
  assign any   = |cand;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (cand[i]) idx = IDX_W'(i);
  end

endmodule

// File: rtl/msg_out_stage.sv
module msg_out_stage
  import irq_redir_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] pin_in,
  input  msg_t             msg_in,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] pin_out,
  output msg_t             msg_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      pin_out <= '0;
      msg_out <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      pin_out <= pin_in;
      msg_out <= msg_in;
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int LINE_W   = 6,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_stb,
  input  logic [LINE_W-1:0]   req_line,
  input  logic                req_lvl,
  input  logic                eoi_stb,
  input  logic [7:0]          eoi_vec,
  input  logic                resvc,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [63:0]         cfg_data,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [IDX_W-1:0]    msg_pin,
  output logic [7:0]          msg_dest,
  output logic                msg_dmode,
  output logic [2:0]          msg_dlv,
  output logic [7:0]          msg_vec,
  output logic                msg_pol,
  output logic                msg_trig,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] rirr_o
);

  rte_t                ent [NUM_PINS];
  logic [NUM_PINS-1:0] mask_v;
  logic [NUM_PINS-1:0] trig_v;
  logic [7:0]          vec_a [NUM_PINS];
  logic [NUM_PINS-1:0] cand;
  logic [NUM_PINS-1:0] grant;
  logic [NUM_PINS-1:0] take;
  logic [IDX_W-1:0]    sel_idx;
  logic                sel_any;
  logic                take_any;
  msg_t                sel_msg;
  msg_t                out_msg;

  redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_data), .ent(ent)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fld
    assign mask_v[i] = ent[i].mask;
    assign trig_v[i] = ent[i].trig;
    assign vec_a[i]  = ent[i].vec;
  end

  pend_tracker #(.NUM_PINS(NUM_PINS), .LINE_W(LINE_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .req_stb(req_stb), .req_line(req_line), .req_lvl(req_lvl),
    .eoi_stb(eoi_stb), .eoi_vec(eoi_vec), .resvc(resvc),
    .mask_v(mask_v), .trig_v(trig_v), .vec_a(vec_a),
    .take(take), .pend(pend_o), .rirr(rirr_o), .cand(cand)
  );

  pick_lowest #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .grant(grant), .idx(sel_idx), .any(sel_any)
  );

  // Side effects of an issue are committed when the message is loaded.
  assign take_any = sel_any && (!msg_valid || msg_ready);
  assign take     = grant & {NUM_PINS{take_any}};
  assign sel_msg  = rte_to_msg(ent[sel_idx]);

  msg_out_stage #(.IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(take_any), .pin_in(sel_idx), .msg_in(sel_msg),
    .ready(msg_ready), .valid(msg_valid), .pin_out(msg_pin), .msg_out(out_msg)
  );

  assign msg_dest  = out_msg.dest;
  assign msg_dmode = out_msg.dmode;
  assign msg_dlv   = out_msg.dlv;
  assign msg_vec   = out_msg.vec;
  assign msg_pol   = out_msg.pol;
  assign msg_trig  = out_msg.trig;

endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_stb,
  input logic                load,
  input logic [NUM_PINS-1:0] grant,
  input logic [NUM_PINS-1:0] trig_v,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] rirr,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [IDX_W+21:0]   msg_bits
);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_bits));

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_level_marks_rirr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load && |(grant & trig_v) |=> |($past(grant) & rirr));

  assert_edge_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load && |(grant & ~trig_v) && !req_stb |=> ($past(grant) & pend) == '0);

  assert_rirr_rise_needs_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    |(rirr & ~$past(rirr)) |-> $past(load));

endmodule

bind irq_redirect_engine irq_redirect_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .load(take_any), .grant(grant),
  .trig_v(trig_v), .pend(pend_o), .rirr(rirr_o),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_bits({msg_pin, msg_dest, msg_dmode, msg_dlv, msg_vec, msg_pol, msg_trig})
);

// File: tb/irq_redirect_engine_tb.sv
`timescale 1ns/1ps
module irq_redirect_engine_tb;

  localparam int NP = 24;
  localparam int LW = 6;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_stb = 1'b0, req_lvl = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic          eoi_stb = 1'b0;
  logic [7:0]    eoi_vec = '0;
  logic          resvc = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [63:0]   cfg_data = '0;
  logic          msg_valid, msg_ready;
  logic [IW-1:0] msg_pin;
  logic [7:0]    msg_dest, msg_vec;
  logic          msg_dmode, msg_pol, msg_trig;
  logic [2:0]    msg_dlv;
  logic [NP-1:0] pend_o, rirr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [26:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_redirect_engine #(.NUM_PINS(NP), .LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_line(req_line), .req_lvl(req_lvl),
    .eoi_stb(eoi_stb), .eoi_vec(eoi_vec), .resvc(resvc),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
    .msg_dest(msg_dest), .msg_dmode(msg_dmode), .msg_dlv(msg_dlv), .msg_vec(msg_vec),
    .msg_pol(msg_pol), .msg_trig(msg_trig), .pend_o(pend_o), .rirr_o(rirr_o)
  );

  function automatic logic [63:0] mk(input logic [7:0] dest, input logic [7:0] vec,
                                     input logic [2:0] dlv, input logic dmode,
                                     input logic pol, input logic trig, input logic mask);
    logic [63:0] w;
    w = 64'(vec);
    w = w | (64'(dlv) << 8) | (64'(dmode) << 11) | (64'(pol) << 13);
    w = w | (64'(trig) << 15) | (64'(mask) << 16) | (64'(dest) << 56);
    return w;
  endfunction

  function automatic logic [26:0] expm(input int pin, input logic [63:0] w);
    logic [2:0] k;
    logic [7:0] v;
    k = 3'((w >> 8) & 64'h7);
    v = (k == 3'd7) ? 8'h00 : 8'(w & 64'hff);
    return {5'(pin), 8'(w >> 56), 1'((w >> 11) & 1), k, v, 1'((w >> 13) & 1), 1'((w >> 15) & 1)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push(input int pin, input logic [63:0] w, input string tag);
    exp_q.push_back(expm(pin, w));
    tag_q.push_back(tag);
  endtask

  task automatic wr_ent(input int idx, input logic [63:0] w);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_data = w;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic req(input int line, input logic lvl, input int len = 1);
    req_stb = 1'b1; req_line = LW'(line); req_lvl = lvl;
    tick(len);
    req_stb = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_stb = 1'b1; eoi_vec = v;
    tick();
    eoi_stb = 1'b0;
  endtask

  task automatic pulse_resvc();
    resvc = 1'b1;
    tick();
    resvc = 1'b0;
  endtask

  // Scoreboard monitor: a handshake seen here completes at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      logic [26:0] got;
      got = {msg_pin, msg_dest, msg_dmode, msg_dlv, msg_vec, msg_pol, msg_trig};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected message act=%0h exp=none", got);
      end else begin
        logic [26:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          bad++;
          $display("FAIL %s message act=%0h exp=%0h", t, got, e);
        end
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<20000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] w5, w9, w2, w0, w3, w12, w20, w14, w17, w7;
    logic [NP-1:0] saved;
    msg_ready = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1: reset state, words masked
    chk(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 0);
    chk(pend_o == '0, "R1 pend", 64'(pend_o), 0);
    chk(rirr_o == '0, "R1 rirr", 64'(rirr_o), 0);
    req(5, 1'b1);
    tick(4);
    chk(pend_o == '0 && msg_valid == 1'b0, "R1 masked after reset", 64'(pend_o), 0);

    // R2 / R3: edge pin, distinct field values
    w5 = mk(8'h3C, 8'h41, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    wr_ent(5, w5);
    push(5, w5, "R2 R3 edge fields");
    req(5, 1'b1);
    tick(5);
    chk(pend_o[5] == 1'b0, "R3 pend cleared", 64'(pend_o[5]), 0);
    chk(exp_q.size() == 0, "R3 delivered", 64'(exp_q.size()), 0);

    // R4: masked edge dropped
    wr_ent(6, mk(8'h01, 8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    req(6, 1'b1);
    tick(3);
    chk(pend_o[6] == 1'b0, "R4 pend stays 0", 64'(pend_o[6]), 0);
    wr_ent(6, mk(8'h01, 8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse_resvc();
    tick(4);
    chk(msg_valid == 1'b0, "R4 no message after unmask", 64'(msg_valid), 0);

    // R5: level pin
    w9 = mk(8'h09, 8'h61, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    wr_ent(9, w9);
    push(9, w9, "R5 level");
    req(9, 1'b1);
    tick(5);
    chk(pend_o[9] == 1'b1, "R5 pend set", 64'(pend_o[9]), 1);
    chk(rirr_o[9] == 1'b1, "R5 rirr set", 64'(rirr_o[9]), 1);
    pulse_resvc();
    tick(4);
    chk(exp_q.size() == 0 && msg_valid == 1'b0, "R5 no redelivery", 64'(msg_valid), 0);
    req(9, 1'b0);
    tick();
    chk(pend_o[9] == 1'b0, "R5 deassert clears", 64'(pend_o[9]), 0);

    // R6: end-of-interrupt handling
    req(9, 1'b1);
    tick(3);
    eoi(8'h62);
    tick(3);
    chk(rirr_o[9] == 1'b1, "R6 other vector keeps flag", 64'(rirr_o[9]), 1);
    push(9, w9, "R6 redelivery");
    eoi(8'h61);
    tick(5);
    chk(rirr_o[9] == 1'b1 && exp_q.size() == 0, "R6 redelivered", 64'(rirr_o[9]), 1);
    req(9, 1'b0);
    eoi(8'h61);
    tick(4);
    chk(rirr_o[9] == 1'b0, "R6 flag cleared", 64'(rirr_o[9]), 0);

    // R7: line remap and out-of-range lines
    w0 = mk(8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    w2 = mk(8'h22, 8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_ent(0, w0);
    wr_ent(2, w2);
    push(2, w2, "R7 line0 to pin2");
    req(0, 1'b1);
    tick(5);
    chk(pend_o[0] == 1'b0 && exp_q.size() == 0, "R7 remap", 64'(exp_q.size()), 0);
    saved = pend_o;
    req(24, 1'b1);
    req(31, 1'b1);
    tick(4);
    chk(pend_o == saved && msg_valid == 1'b0, "R7 out of range ignored", 64'(pend_o), 64'(saved));

    // R8 / R9: ascending order under back-pressure
    w3  = mk(8'hA3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    w12 = mk(8'hAC, 8'h3C, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0);
    w20 = mk(8'hB4, 8'h34, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    wr_ent(3, w3); wr_ent(12, w12); wr_ent(20, w20);
    msg_ready = 1'b0;
    push(20, w20, "R9 first");
    push(3, w3, "R8 lowest first");
    push(12, w12, "R8 next");
    req(20, 1'b1);
    req(12, 1'b1);
    req(3, 1'b1);
    tick(3);
    chk(msg_valid == 1'b1 && msg_pin == IW'(20) && msg_vec == 8'h34, "R9 held", 64'(msg_pin), 20);
    tick(3);
    chk(msg_pin == IW'(20) && msg_dest == 8'hB4, "R9 still held", 64'(msg_dest), 64'hB4);
    msg_ready = 1'b1;
    tick(6);
    chk(exp_q.size() == 0, "R8 all delivered", 64'(exp_q.size()), 0);

    // R10: external-fetch kind clears vector
    w14 = mk(8'h0E, 8'h77, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_ent(14, w14);
    push(14, w14, "R10 vector zero");
    req(14, 1'b1);
    tick(5);
    chk(exp_q.size() == 0, "R10 delivered", 64'(exp_q.size()), 0);

    // R11: unmask by rewrite waits for re-service pulse
    w17 = mk(8'h11, 8'h71, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    wr_ent(17, w17);
    req(17, 1'b1);
    tick(3);
    chk(pend_o[17] == 1'b1 && msg_valid == 1'b0, "R11 pending masked", 64'(pend_o[17]), 1);
    w17 = mk(8'h11, 8'h71, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    wr_ent(17, w17);
    tick(5);
    chk(msg_valid == 1'b0 && rirr_o[17] == 1'b0, "R11 waits for pulse", 64'(msg_valid), 0);
    push(17, w17, "R11 after pulse");
    pulse_resvc();
    tick(5);
    chk(rirr_o[17] == 1'b1 && exp_q.size() == 0, "R11 delivered", 64'(rirr_o[17]), 1);
    req(17, 1'b0);
    eoi(8'h71);
    tick(3);

    // R12: re-request on the issue edge survives
    w7 = mk(8'h07, 8'h27, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    wr_ent(7, w7);
    push(7, w7, "R12 first");
    push(7, w7, "R12 second");
    req(7, 1'b1, 2);
    tick(6);
    chk(exp_q.size() == 0 && pend_o[7] == 1'b0, "R12 two messages", 64'(exp_q.size()), 0);

    // R13: written bit 14 does not reach the remote flag
    wr_ent(4, mk(8'h04, 8'h44, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0) | 64'h4000);
    tick(2);
    chk(rirr_o[4] == 1'b0 && msg_valid == 1'b0, "R13 flag untouched", 64'(rirr_o[4]), 0);

    tick(4);
    chk(exp_q.size() == 0, "R9 no missing message", 64'(exp_q.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule